// File: doc/BRIEF.md
# SDRAM Clock-Enable State Controller

This block models the power and suspend behaviour of a synchronous DRAM device. On every rising clock edge it looks at the clock-enable pin as it is now and as it was one edge earlier. It also decodes the four command pins (chip select, row strobe, column strobe, write enable) and a burst-end status input. From these it tracks whether the device is idle, has a bank open, is bursting a read or a write, is clock-suspended, is powered down, is in self-refresh, or is busy with an auto-refresh.

Suspend is entered from any open-bank state. A falling clock-enable edge causes the entry. The kind of suspend depends on what the device was doing on the clock before entry. A read suspend asks the data path to keep driving its current output, a write suspend asks it to reject external data, and any suspend freezes the data path. The refresh command code does one of two things depending on clock enable. With clock enable held high it runs an auto-refresh. With clock enable falling it enters self-refresh. An internal row counter advances on each auto-refresh and on a fixed tick while in self-refresh. Commands that are not allowed in the current state raise a one-cycle flag.

Top module: `sdram_cke_fsm`

## Requirements
- R1: While `rst` is sampled high at a clock edge, the block goes to idle (state 0), clears `rf_addr`, drops `freeze`, `dq_hold`, `wr_lock` and `illegal`, and treats clock enable as high on the previous edge.
- R2: State codes: 0 idle, 1 active, 2 read, 3 write, 4 suspend, 5 power-down, 6 self-refresh, 7 refresh-busy. Command codes on {cs_n,ras_n,cas_n,we_n}: 0111 no-op, 1xxx deselect, 0011 activate, 0101 read, 0100 write, 0010 precharge, 0001 refresh, 0000 mode set, 0110 burst stop. With clock enable high, activate moves idle to active. Read and write move any open-bank state to read or write, and precharge returns it to idle. Burst stop, or `burst_end` with no other command, returns read or write to active.
- R3: In active, read or write, clock enable high on the previous edge and low now enters suspend. The command sampled at that edge still takes effect, and the suspend kind is the state held before that edge.
- R4: Suspend persists while clock enable stays low, and every command is ignored. Clock enable rising leaves suspend for the state the entry-edge command produced.
- R5: `freeze` is high exactly in suspend. `dq_hold` is high only in a suspend entered from read. `wr_lock` is high only in a suspend entered from write.
- R6: Refresh in idle with clock enable high on both edges enters refresh-busy and advances `rf_addr` by one. The state stays refresh-busy for BUSY cycles (default 9) and then returns to idle.
- R7: Refresh in idle with clock enable falling enters self-refresh. There `rf_addr` advances once every SREF_TICK clocks (default 16), counted from entry.
- R8: A no-op or deselect in idle with clock enable falling enters power-down. In idle, commands are not decoded when clock enable was low on the previous edge.
- R9: Power-down and self-refresh exit to idle only on a clock-enable rising edge that carries a no-op or deselect. Otherwise they hold.
- R10: A disallowed command raises `illegal` for one cycle, and the state does not move because of it. Disallowed means: read, write or burst stop in idle; refresh or mode set in an open-bank state; anything but refresh, no-op or deselect in idle with clock enable falling; anything but no-op or deselect during refresh-busy, where the countdown continues.
- R11: `rf_addr` wraps from ROWS-1 (default 8191) to 0.
- R12: A reset taken in self-refresh or refresh-busy returns the block to idle with `rf_addr` at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cke | input | 1 | Clock-enable pin |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| burst_end | input | 1 | Current read or write burst has finished |
| state | output | 3 | Current state code (R2) |
| freeze | output | 1 | Data path clock frozen |
| dq_hold | output | 1 | Keep driving the current read data |
| wr_lock | output | 1 | Reject external write data |
| illegal | output | 1 | One-cycle disallowed-command flag |
| rf_addr | output | $clog2(ROWS) | Internal refresh row/bank counter |

## Verification
The hardest case is counter wrap. It needs 8192 refreshes, and each one is followed by nine busy cycles, so only a long directed loop of refresh and no-op pairs reaches it. The next hardest is a suspend whose entry edge carries a read or write from another burst state. That needs clock enable to fall on exactly the edge of a state-changing command. Directed sequences place the falling edge on that command, and the random phase makes clock enable persist for several cycles before it flips so that such edges recur.

// File: rtl/sdram_cke_fsm.sv
module sdram_cke_fsm #(
  parameter int ROWS      = 8192,
  parameter int BUSY      = 9,
  parameter int SREF_TICK = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cke,
  input  logic                    cs_n,
  input  logic                    ras_n,
  input  logic                    cas_n,
  input  logic                    we_n,
  input  logic                    burst_end,
  output logic [2:0]              state,
  output logic                    freeze,
  output logic                    dq_hold,
  output logic                    wr_lock,
  output logic                    illegal,
  output logic [$clog2(ROWS)-1:0] rf_addr
);
  localparam int AW = $clog2(ROWS);
  localparam int BW = $clog2(BUSY + 1);
  localparam int TW = $clog2(SREF_TICK + 1);

  localparam logic [2:0] S_IDLE = 3'd0, S_ACT = 3'd1, S_RD = 3'd2, S_WR = 3'd3,
                         S_SUSP = 3'd4, S_PDN = 3'd5, S_SREF = 3'd6, S_ARF = 3'd7;

  logic          cke_q;
  logic [2:0]    st, nx, run, ret, kind;
  logic          bad;
  logic [BW-1:0] bcnt;
  logic [TW-1:0] tcnt;
  logic [AW-1:0] addr_inc;

  wire [3:0] cmd    = {cs_n, ras_n, cas_n, we_n};
  wire       nopd   = cs_n | (cmd == 4'b0111);
  wire       is_act = cmd == 4'b0011;
  wire       is_rd  = cmd == 4'b0101;
  wire       is_wr  = cmd == 4'b0100;
  wire       is_pre = cmd == 4'b0010;
  wire       is_ref = cmd == 4'b0001;
  wire       is_mrs = cmd == 4'b0000;
  wire       is_bst = cmd == 4'b0110;
  wire       fall   = cke_q & ~cke;
  wire       rise   = ~cke_q & cke;

  assign addr_inc = (rf_addr == AW'(ROWS - 1)) ? '0 : rf_addr + 1'b1;

  always_comb begin
    nx  = st;
    run = st;
    bad = 1'b0;
    case (st)
      S_IDLE:
        if (cke_q) begin
          if (cke) begin
            if (is_ref) nx = S_ARF;
            else if (is_act) nx = S_ACT;
            else if (is_rd | is_wr | is_bst) bad = 1'b1;
          end else begin
            if (is_ref) nx = S_SREF;
            else if (nopd) nx = S_PDN;
            else bad = 1'b1;
          end
        end
      S_ACT, S_RD, S_WR: begin
        if (is_rd) run = S_RD;
        else if (is_wr) run = S_WR;
        else if (is_pre) run = S_IDLE;
        else if (is_bst) run = S_ACT;
        else if (is_ref | is_mrs) bad = 1'b1;
        else if (burst_end) run = S_ACT;
        nx = fall ? S_SUSP : run;
      end
      S_SUSP: if (rise) nx = ret;
      S_PDN, S_SREF: if (rise && nopd) nx = S_IDLE;
      default: begin
        if (!nopd) bad = 1'b1;
        if (bcnt == '0) nx = S_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= S_IDLE;
      cke_q   <= 1'b1;
      ret     <= S_IDLE;
      kind    <= S_IDLE;
      bcnt    <= '0;
      tcnt    <= '0;
      rf_addr <= '0;
      illegal <= 1'b0;
    end else begin
      st      <= nx;
      cke_q   <= cke;
      illegal <= bad;
      if (nx == S_SUSP && st != S_SUSP) begin
        ret  <= run;
        kind <= st;
      end
      if (st == S_IDLE && nx == S_ARF) begin
        bcnt    <= BW'(BUSY - 1);
        rf_addr <= addr_inc;
      end else if (st == S_ARF && bcnt != '0) begin
        bcnt <= bcnt - 1'b1;
      end
      if (st != S_SREF) begin
        tcnt <= '0;
      end else if (nx == S_SREF) begin
        if (tcnt == TW'(SREF_TICK - 1)) begin
          tcnt    <= '0;
          rf_addr <= addr_inc;
        end else begin
          tcnt <= tcnt + 1'b1;
        end
      end
    end
  end

  assign state   = st;
  assign freeze  = st == S_SUSP;
  assign dq_hold = freeze && kind == S_RD;
  assign wr_lock = freeze && kind == S_WR;

  // R3
  susp_entry_chk: assert property (@(posedge clk) disable iff (rst)
    ((st == S_ACT || st == S_RD || st == S_WR) && !cke) |=> st == S_SUSP);

  // R4
  susp_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (st == S_SUSP && !cke) |=> st == S_SUSP);

  // R9
  sref_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (st == S_SREF && !(cke && nopd)) |=> st == S_SREF);

  // R8
  pdn_entry_chk: assert property (@(posedge clk) disable iff (rst)
    (st == S_PDN && $past(st) != S_PDN) |-> ($past(st) == S_IDLE && !$past(cke)));

  // R6
  arf_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (st == S_ARF && $past(st) != S_ARF) |->
      rf_addr == (($past(rf_addr) == AW'(ROWS - 1)) ? '0 : $past(rf_addr) + 1'b1));

  // R10
  illegal_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (illegal && $past(cke) && $past(st) != S_ARF) |-> st == $past(st));
endmodule

// File: tb/sdram_cke_fsm_test.sv
`timescale 1ns/1ps
module sdram_cke_fsm_test;
  localparam int ROWS = 8192, BUSY = 9, TICK = 16;
  localparam logic [3:0] NOP = 4'b0111, DES = 4'b1111, ACT = 4'b0011, RD = 4'b0101,
                         WR = 4'b0100, PRE = 4'b0010, REF = 4'b0001, MRS = 4'b0000,
                         BST = 4'b0110;

  logic clk = 0, rst = 1, cke = 1, cs_n = 1, ras_n = 1, cas_n = 1, we_n = 1, burst_end = 0;
  logic [2:0] state;
  logic freeze, dq_hold, wr_lock, illegal;
  logic [12:0] rf_addr;

  sdram_cke_fsm #(.ROWS(ROWS), .BUSY(BUSY), .SREF_TICK(TICK)) uut (
    .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .burst_end(burst_end), .state(state), .freeze(freeze),
    .dq_hold(dq_hold), .wr_lock(wr_lock), .illegal(illegal), .rf_addr(rf_addr));

  always #10 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  int m_st = 0, m_ret = 0, m_kind = 0, m_b = 0, m_t = 0, m_addr = 0;
  bit m_prev = 1, m_ill = 0;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int bump(input int a);
    return (a == ROWS - 1) ? 0 : a + 1;
  endfunction

  task automatic model(input bit r, input bit c, input logic [3:0] k, input bit be);
    bit nd, pv;
    int nxt, rs;
    nd = k[3] || k == NOP;
    pv = m_prev;
    if (r) begin
      m_st = 0; m_ret = 0; m_kind = 0; m_b = 0; m_t = 0; m_addr = 0;
      m_prev = 1; m_ill = 0;
      return;
    end
    m_ill = 0;
    nxt = m_st;
    case (m_st)
      0: if (pv) begin
        if (c) begin
          if (!k[3] && k == REF) begin nxt = 7; m_b = BUSY - 1; m_addr = bump(m_addr); end
          else if (!k[3] && k == ACT) nxt = 1;
          else if (!k[3] && (k == RD || k == WR || k == BST)) m_ill = 1;
        end else begin
          if (!k[3] && k == REF) begin nxt = 6; m_t = 0; end
          else if (nd) nxt = 5;
          else m_ill = 1;
        end
      end
      1, 2, 3: begin
        rs = m_st;
        if (!k[3]) begin
          case (k)
            RD: rs = 2;
            WR: rs = 3;
            PRE: rs = 0;
            BST: rs = 1;
            REF, MRS: m_ill = 1;
            default: if (be) rs = 1;
          endcase
        end else if (be) rs = 1;
        if (pv && !c) begin m_ret = rs; m_kind = m_st; nxt = 4; end
        else nxt = rs;
      end
      4: if (!pv && c) nxt = m_ret;
      5: if (!pv && c && nd) nxt = 0;
      6: if (!pv && c && nd) nxt = 0;
         else if (m_t == TICK - 1) begin m_t = 0; m_addr = bump(m_addr); end
         else m_t++;
      default: begin
        if (!nd) m_ill = 1;
        if (m_b == 0) nxt = 0; else m_b--;
      end
    endcase
    m_st = nxt;
    m_prev = c;
  endtask

  task automatic compare_all();
    chk("R2 state", state, m_st);
    chk("R6 rf_addr", rf_addr, m_addr);
    chk("R5 freeze", freeze, m_st == 4);
    chk("R5 dq_hold", dq_hold, m_st == 4 && m_kind == 2);
    chk("R5 wr_lock", wr_lock, m_st == 4 && m_kind == 3);
    chk("R10 illegal", illegal, m_ill);
  endtask

  task automatic cyc(input bit c, input logic [3:0] k, input bit be);
    @(negedge clk);
    rst = 0; cke = c; {cs_n, ras_n, cas_n, we_n} = k; burst_end = be;
    @(posedge clk);
    model(0, c, k, be);
    #1 compare_all();
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; cke = 1; {cs_n, ras_n, cas_n, we_n} = DES; burst_end = 0;
    @(posedge clk);
    model(1, 1, DES, 0);
    #1 compare_all();
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int a0;
    bit c;
    logic [3:0] k;
    void'($urandom(32'd20240611));
    do_reset(); do_reset();
    // R1 reset state
    chk("R1", state, 0); chk("R1", rf_addr, 0); chk("R1", freeze, 0); chk("R1", illegal, 0);

    // R2 R3 R4 R5 read suspend
    cyc(1, ACT, 0); chk("R2", state, 1);
    cyc(1, RD, 0);  chk("R2", state, 2);
    cyc(0, NOP, 0); chk("R3", state, 4); chk("R5", dq_hold, 1);
    cyc(0, WR, 0);  chk("R4", state, 4); chk("R4", dq_hold, 1);
    cyc(1, NOP, 0); chk("R4", state, 2);
    // R3 entry-edge command executes
    cyc(0, WR, 0);  chk("R3", state, 4); chk("R5", wr_lock, 0);
    cyc(1, NOP, 0); chk("R3", state, 3);
    cyc(0, NOP, 0); chk("R5", wr_lock, 1); chk("R5", dq_hold, 0);
    cyc(1, NOP, 0); chk("R4", state, 3);
    cyc(1, NOP, 1); chk("R2", state, 1);
    // R10 refresh with bank open
    cyc(1, REF, 0); chk("R10", state, 1); chk("R10", illegal, 1);
    cyc(1, NOP, 0); chk("R10", illegal, 0);
    cyc(1, PRE, 0); chk("R2", state, 0);
    // R6 auto-refresh
    a0 = rf_addr;
    cyc(1, REF, 0); chk("R6", state, 7); chk("R6", rf_addr, a0 + 1);
    repeat (BUSY - 1) cyc(1, NOP, 0);
    chk("R6", state, 7);
    cyc(1, NOP, 0); chk("R6", state, 0);
    // R8 R9 power-down
    cyc(0, NOP, 0); chk("R8", state, 5);
    cyc(1, ACT, 0); chk("R9", state, 5);
    cyc(0, NOP, 0); chk("R9", state, 5);
    cyc(1, DES, 0); chk("R9", state, 0);
    // R7 self-refresh ticks
    a0 = rf_addr;
    cyc(0, REF, 0); chk("R7", state, 6); chk("R7", rf_addr, a0);
    repeat (2 * TICK) cyc(0, NOP, 0);
    chk("R7", rf_addr, a0 + 2);
    cyc(1, NOP, 0); chk("R9", state, 0);
    // R8 R10 bad command with falling enable in idle
    cyc(0, ACT, 0); chk("R8", state, 0); chk("R10", illegal, 1);
    cyc(1, ACT, 0); chk("R8", state, 0);
    // R12 reset from self-refresh
    cyc(1, NOP, 0); cyc(0, REF, 0); repeat (20) cyc(0, NOP, 0);
    do_reset(); chk("R12", state, 0); chk("R12", rf_addr, 0);

    // random phase
    c = 1;
    for (int i = 0; i < 30000; i++) begin
      int r;
      if ($urandom % 2000 == 0) begin do_reset(); c = 1; continue; end
      if ($urandom % 5 == 0) c = ~c;
      r = $urandom % 16;
      case (r)
        0, 1, 2, 3, 4, 5: k = NOP;
        6, 7: k = DES | 4'($urandom % 8);
        8, 15: k = ACT;
        9: k = RD;
        10: k = WR;
        11: k = PRE;
        12: k = REF;
        13: k = MRS;
        default: k = BST;
      endcase
      cyc(c, k, ($urandom % 4) == 0);
    end

    // R11 wrap
    do_reset();
    for (int i = 0; i < ROWS; i++) begin
      cyc(1, REF, 0);
      if (i == ROWS - 2) chk("R11", rf_addr, ROWS - 1);
      repeat (BUSY) cyc(1, NOP, 0);
    end
    chk("R11", rf_addr, 0);
    chk("R11", state, 0);
    finish_run();
  end
endmodule